// File: doc/BRIEF.md
# Dual-Network Iterative Block Cipher Round Engine

This block encrypts a 64-bit data block under a 96-bit key by iterating a round once per clock for 32 clocks. Two different round networks are built: a substitution-permutation network (nibble substitution plus matrix diffusion over a 4x4 nibble grid) and a Feistel-style network (nibble substitution, bit permutation and XOR-only word mixing). In every round one network transforms the data block while the other advances the key state. The upper 32 key bits are never used as key material. Each of these bits chooses which network takes which job in its round.

A host pulses a start input while the engine is idle. The plaintext and the key are captured on that edge, and a busy flag covers the 32 round cycles. A one-cycle done pulse then marks the ciphertext output as valid. The substitution tables, the diffusion coefficients, the bit permutation and the word-mixing pattern are parameters of the top module. The defaults are computed in the shared package.

Top module: `dualnet_cipher`

## Requirements
- R1: A start pulse sampled while busy is low loads the plaintext, the 64 low key bits (key state) and the 32 high key bits (control word), and busy is high from the next cycle.
- R2: Busy stays high for exactly 32 cycles. On the cycle busy falls, done is high for exactly one cycle and the ciphertext output carries the result of the 32 rounds.
- R3: A start pulse that arrives while busy is high is ignored. The run keeps its length and its result, and the new inputs are not loaded.
- R4: Round i (0 to 31) is controlled by control bit i, which is key bit 64+i. When the bit is 0, the substitution-permutation network transforms the data and the Feistel network updates the key. When the bit is 1, the roles are exchanged.
- R5: The substitution-permutation network XORs its round key, substitutes every nibble through table A, mixes columns, mixes rows, and substitutes through table A again. Nibble n = 4*row+col sits in bits 4n+3..4n. Column mixing gives out[r][c] = XOR over k of M[r][k]*in[k][c]. Row mixing gives out[r][c] = XOR over k of M[c][k]*in[r][k]. Products are in GF(16) with polynomial x^4+x+1, and M[r][k] is coefficient nibble 4r+k.
- R6: The Feistel network XORs its round key, substitutes through table B, and moves input bit i to output bit PERM[6i+5:6i]. It then replaces each 16-bit word w_i (bits 16i+15..16i) by the XOR of the words w_j for which mask bit 4i+j is set, and substitutes through table B again. Table entry v of a 64-bit table is bits 4v+3..4v.
- R7: The data network sees the data with its two 32-bit halves swapped, and its result is half-swapped again before it is stored. The data round key is the current 64-bit key state.
- R8: The key state is replaced each round by the other network's output for that key state. That network's round key is the round index zero-extended to 64 bits. The control word is not modified.
- R9: During and after asynchronous active-low reset, busy and done are low and the ciphertext output is zero.
- R10: While idle with no start, the ciphertext output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts an encryption when idle |
| pt_i | input | 64 | Plaintext block |
| key_i | input | 96 | Key: bits 63..0 key material, bits 95..64 per-round control |
| busy_o | output | 1 | High during the 32 round cycles |
| done_o | output | 1 | One-cycle pulse, ciphertext valid |
| ct_o | output | 64 | Ciphertext |

## Verification
The bench goes after control words of all zeros, all ones and alternating bits. These isolate each network on the data path and on the key path. A design that mixed up the role assignment, took the wrong control bit, or dropped a half swap would therefore give a ciphertext different from the bench model. A start raised in the middle of a run checks that the run is not restarted or reloaded. Such a fault would show up as a longer busy window or a ciphertext computed from the intruding inputs. Idle cycles after done, with the inputs changing, catch an output register that reloads without a start. Cycle-exact sampling of busy and done catches off-by-one round counts.

// File: rtl/dualnet_pkg.sv
package dualnet_pkg;

  localparam logic [63:0] SBOX_A_DEF = 64'h21748FE3DA09B65C;
  localparam logic [63:0] SBOX_B_DEF = 64'h24F8D30B97E1AC56;
  localparam logic [63:0] MDS_DEF    = 64'h2113321113211132;
  localparam logic [15:0] MIX_DEF    = 16'hBDE7;

  // bit i of the state moves to bit (16*i mod 63), bit 63 stays
  function automatic logic [383:0] perm_def();
    logic [383:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) begin
      int d;
      d = (i == 63) ? 63 : (i * 16) % 63;
      r[i*6 +: 6] = 6'(d);
    end
    return r;
  endfunction

  function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p;
    logic [3:0] aa;
    p  = '0;
    aa = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p = p ^ aa;
      aa = aa[3] ? ({aa[2:0], 1'b0} ^ 4'h3) : {aa[2:0], 1'b0};
    end
    return p;
  endfunction

  // product table, entry (a,b) at bits 4*(16a+b)+3 .. 4*(16a+b)
  function automatic logic [1023:0] gf16_table();
    logic [1023:0] t;
    t = '0;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        t[(a*16+b)*4 +: 4] = gf16_mul(4'(a), 4'(b));
      end
    end
    return t;
  endfunction

endpackage

// File: rtl/dn_sbox_layer.sv
module dn_sbox_layer #(
  parameter int          W     = 64,
  parameter logic [63:0] TABLE = dualnet_pkg::SBOX_A_DEF
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NIBS = W / 4;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign dout[4*g +: 4] = TABLE[{din[4*g +: 4], 2'b00} +: 4];
  end
endmodule

// File: rtl/dn_sp_net.sv
module dn_sp_net #(
  parameter int          W    = 64,
  parameter logic [63:0] SBOX = dualnet_pkg::SBOX_A_DEF,
  parameter logic [63:0] MDS  = dualnet_pkg::MDS_DEF
) (
  input  logic [W-1:0] din,
  input  logic [W-1:0] rk,
  output logic [W-1:0] dout
);
  localparam int DIM = 4;
  localparam logic [1023:0] MUL_LUT = dualnet_pkg::gf16_table();

  logic [W-1:0] keyed;
  logic [W-1:0] sub0;
  logic [W-1:0] colm;
  logic [W-1:0] rowm;

  assign keyed = din ^ rk;

  dn_sbox_layer #(.W(W), .TABLE(SBOX)) u_sub_in (.din(keyed), .dout(sub0));

  function automatic logic [3:0] lut_mul(input logic [3:0] coef, input logic [3:0] x);
    return MUL_LUT[{coef, x, 2'b00} +: 4];
  endfunction

  always_comb begin
    colm = '0;
    for (int r = 0; r < DIM; r++) begin
      for (int c = 0; c < DIM; c++) begin
        for (int k = 0; k < DIM; k++) begin
          colm[(r*DIM+c)*4 +: 4] = colm[(r*DIM+c)*4 +: 4]
            ^ lut_mul(MDS[(r*DIM+k)*4 +: 4], sub0[(k*DIM+c)*4 +: 4]);
        end
      end
    end
  end

  always_comb begin
    rowm = '0;
    for (int r = 0; r < DIM; r++) begin
      for (int c = 0; c < DIM; c++) begin
        for (int k = 0; k < DIM; k++) begin
          rowm[(r*DIM+c)*4 +: 4] = rowm[(r*DIM+c)*4 +: 4]
            ^ lut_mul(MDS[(c*DIM+k)*4 +: 4], colm[(r*DIM+k)*4 +: 4]);
        end
      end
    end
  end

  dn_sbox_layer #(.W(W), .TABLE(SBOX)) u_sub_out (.din(rowm), .dout(dout));
endmodule

// File: rtl/dn_fs_net.sv
module dn_fs_net #(
  parameter int           W    = 64,
  parameter logic [63:0]  SBOX = dualnet_pkg::SBOX_B_DEF,
  parameter logic [383:0] PERM = dualnet_pkg::perm_def(),
  parameter logic [15:0]  MIX  = dualnet_pkg::MIX_DEF
) (
  input  logic [W-1:0] din,
  input  logic [W-1:0] rk,
  output logic [W-1:0] dout
);
  localparam int WORDS = 4;
  localparam int WW    = W / WORDS;

  logic [W-1:0] keyed;
  logic [W-1:0] sub0;
  logic [W-1:0] perm;
  logic [W-1:0] mixd;

  assign keyed = din ^ rk;

  dn_sbox_layer #(.W(W), .TABLE(SBOX)) u_sub_in (.din(keyed), .dout(sub0));

  always_comb begin
    perm = '0;
    for (int i = 0; i < W; i++) begin
      perm[PERM[i*6 +: 6]] = sub0[i];
    end
  end

  always_comb begin
    mixd = '0;
    for (int i = 0; i < WORDS; i++) begin
      for (int j = 0; j < WORDS; j++) begin
        if (MIX[i*WORDS+j]) mixd[i*WW +: WW] = mixd[i*WW +: WW] ^ perm[j*WW +: WW];
      end
    end
  end

  dn_sbox_layer #(.W(W), .TABLE(SBOX)) u_sub_out (.din(mixd), .dout(dout));
endmodule

// File: rtl/dualnet_cipher.sv
module dualnet_cipher #(
  parameter int           BLK_W  = 64,
  parameter int           ROUNDS = 32,
  parameter logic [63:0]  SBOX_A = dualnet_pkg::SBOX_A_DEF,
  parameter logic [63:0]  SBOX_B = dualnet_pkg::SBOX_B_DEF,
  parameter logic [63:0]  MDS    = dualnet_pkg::MDS_DEF,
  parameter logic [383:0] PERM   = dualnet_pkg::perm_def(),
  parameter logic [15:0]  MIX    = dualnet_pkg::MIX_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [BLK_W-1:0]        pt_i,
  input  logic [BLK_W+ROUNDS-1:0] key_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [BLK_W-1:0]        ct_o
);
  localparam int KEY_W = BLK_W + ROUNDS;
  localparam int HALF  = BLK_W / 2;
  localparam int CNT_W = $clog2(ROUNDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  logic [BLK_W-1:0]  data_q, data_n;
  logic [BLK_W-1:0]  kst_q,  kst_n;
  logic [ROUNDS-1:0] ctl_q,  ctl_n;
  logic [CNT_W-1:0]  cnt_q,  cnt_n;
  logic              busy_q, busy_n;
  logic              done_q, done_n;

  logic              load;
  logic              adv;
  logic              sel;
  logic [BLK_W-1:0]  rc;
  logic [BLK_W-1:0]  d_swap;
  logic [BLK_W-1:0]  sp_in, sp_rk, sp_out;
  logic [BLK_W-1:0]  fs_in, fs_rk, fs_out;
  logic [BLK_W-1:0]  rnd_data;
  logic [BLK_W-1:0]  rnd_key;

  assign load = start_i & ~busy_q;
  assign adv  = busy_q;
  assign sel  = ctl_q[cnt_q];
  assign rc   = BLK_W'(cnt_q);

  assign d_swap = {data_q[HALF-1:0], data_q[BLK_W-1:HALF]};

  // route data and key into the two networks by the control bit
  assign sp_in = sel ? kst_q  : d_swap;
  assign sp_rk = sel ? rc     : kst_q;
  assign fs_in = sel ? d_swap : kst_q;
  assign fs_rk = sel ? kst_q  : rc;

  dn_sp_net #(.W(BLK_W), .SBOX(SBOX_A), .MDS(MDS)) u_sp (
    .din (sp_in),
    .rk  (sp_rk),
    .dout(sp_out)
  );

  dn_fs_net #(.W(BLK_W), .SBOX(SBOX_B), .PERM(PERM), .MIX(MIX)) u_fs (
    .din (fs_in),
    .rk  (fs_rk),
    .dout(fs_out)
  );

  always_comb begin
    logic [BLK_W-1:0] dnet;
    dnet     = sel ? fs_out : sp_out;
    rnd_data = {dnet[HALF-1:0], dnet[BLK_W-1:HALF]};
    rnd_key  = sel ? sp_out : fs_out;
  end

  always_comb begin
    data_n = data_q;
    kst_n  = kst_q;
    ctl_n  = ctl_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (load) begin
      data_n = pt_i;
      kst_n  = key_i[BLK_W-1:0];
      ctl_n  = key_i[KEY_W-1:BLK_W];
      cnt_n  = '0;
      busy_n = 1'b1;
    end else if (adv) begin
      data_n = rnd_data;
      kst_n  = rnd_key;
      cnt_n  = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      if (load || adv) cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      kst_q  <= '0;
      ctl_q  <= '0;
    end else if (load || adv) begin
      data_q <= data_n;
      kst_q  <= kst_n;
      ctl_q  <= ctl_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign ct_o   = data_q;
endmodule

// File: rtl/dualnet_cipher_chk.sv
module dualnet_cipher_chk #(
  parameter int BLK_W  = 64,
  parameter int ROUNDS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [BLK_W-1:0] ct_o
);
  localparam int CW = $clog2(ROUNDS + 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  a_r1_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r2_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_cnt < CW'(ROUNDS)));

  a_r2_done_after_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_cnt == CW'(ROUNDS)));

  a_r2_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && run_cnt != CW'(ROUNDS - 1)) |=> (busy_o && !done_o));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(ct_o));
endmodule

bind dualnet_cipher dualnet_cipher_chk #(.BLK_W(BLK_W), .ROUNDS(ROUNDS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .ct_o   (ct_o)
);

// File: tb/dualnet_cipher_tb.sv
module dualnet_cipher_tb;
  localparam int ROUNDS = 32;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [63:0] pt_i;
  logic [95:0] key_i;
  logic        busy_o;
  logic        done_o;
  logic [63:0] ct_o;

  int n_chk;
  int n_fail;

  localparam logic [63:0]  TA = dualnet_pkg::SBOX_A_DEF;
  localparam logic [63:0]  TB = dualnet_pkg::SBOX_B_DEF;
  localparam logic [63:0]  MM = dualnet_pkg::MDS_DEF;
  localparam logic [383:0] PM = dualnet_pkg::perm_def();
  localparam logic [15:0]  MX = dualnet_pkg::MIX_DEF;

  dualnet_cipher u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pt_i(pt_i),
    .key_i(key_i), .busy_o(busy_o), .done_o(done_o), .ct_o(ct_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [63:0] m_sub(input logic [63:0] x, input logic [63:0] t);
    logic [63:0] r;
    for (int n = 0; n < 16; n++) r[4*n +: 4] = t[4*x[4*n +: 4] +: 4];
    return r;
  endfunction

  function automatic logic [3:0] m_gmul(input logic [3:0] a, input logic [3:0] b);
    logic [7:0] p;
    p = '0;
    for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (8'(a) << i);
    for (int i = 7; i >= 4; i--) if (p[i]) p = p ^ (8'h13 << (i - 4));
    return p[3:0];
  endfunction

  function automatic logic [63:0] m_sp(input logic [63:0] x, input logic [63:0] rk);
    logic [63:0] s, c, r;
    s = m_sub(x ^ rk, TA);
    c = '0; r = '0;
    for (int ro = 0; ro < 4; ro++)
      for (int co = 0; co < 4; co++)
        for (int k = 0; k < 4; k++)
          c[(ro*4+co)*4 +: 4] ^= m_gmul(MM[(ro*4+k)*4 +: 4], s[(k*4+co)*4 +: 4]);
    for (int ro = 0; ro < 4; ro++)
      for (int co = 0; co < 4; co++)
        for (int k = 0; k < 4; k++)
          r[(ro*4+co)*4 +: 4] ^= m_gmul(MM[(co*4+k)*4 +: 4], c[(ro*4+k)*4 +: 4]);
    return m_sub(r, TA);
  endfunction

  function automatic logic [63:0] m_fs(input logic [63:0] x, input logic [63:0] rk);
    logic [63:0] s, p, m;
    s = m_sub(x ^ rk, TB);
    p = '0; m = '0;
    for (int i = 0; i < 64; i++) p[PM[6*i +: 6]] = s[i];
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (MX[4*i+j]) m[16*i +: 16] ^= p[16*j +: 16];
    return m_sub(m, TB);
  endfunction

  function automatic logic [63:0] m_swap(input logic [63:0] x);
    return {x[31:0], x[63:32]};
  endfunction

  function automatic logic [63:0] m_enc(input logic [63:0] pt, input logic [95:0] key);
    logic [63:0] d, k, dn, kn, rc;
    logic [31:0] ctl;
    d = pt; k = key[63:0]; ctl = key[95:64];
    for (int i = 0; i < ROUNDS; i++) begin
      rc = 64'(i);
      if (!ctl[i]) begin
        dn = m_swap(m_sp(m_swap(d), k));
        kn = m_fs(k, rc);
      end else begin
        dn = m_swap(m_fs(m_swap(d), k));
        kn = m_sp(k, rc);
      end
      d = dn; k = kn;
    end
    return d;
  endfunction

  // ---------------- one encryption ----------------
  task automatic run_block(input logic [63:0] pt, input logic [95:0] key,
                           input string tag, input bit poke);
    int          nb;
    logic [63:0] exp;
    logic [63:0] held;
    exp = m_enc(pt, key);
    @(negedge clk);
    start_i = 1'b1; pt_i = pt; key_i = key;
    @(negedge clk);
    start_i = 1'b0; pt_i = ~pt; key_i = ~key;
    check(busy_o == 1'b1, "R1 busy after start", 96'(busy_o), 96'd1);
    nb = 0;
    while (busy_o && nb < 100) begin
      nb++;
      start_i = (poke && nb == 10);
      @(negedge clk);
    end
    start_i = 1'b0;
    if (poke) check(nb == ROUNDS, "R3 run length with start while busy", 96'(nb), 96'(ROUNDS));
    else      check(nb == ROUNDS, "R2 busy length", 96'(nb), 96'(ROUNDS));
    check(done_o == 1'b1, "R2 done at busy fall", 96'(done_o), 96'd1);
    check(ct_o == exp, tag, 96'(ct_o), 96'(exp));
    held = ct_o;
    @(negedge clk);
    check(done_o == 1'b0, "R2 done one cycle", 96'(done_o), 96'd0);
    for (int i = 0; i < 4; i++) begin
      pt_i = pt_i + 64'h1111; key_i = {key_i[94:0], key_i[95]};
      @(negedge clk);
    end
    check(ct_o == held, "R10 output held while idle", 96'(ct_o), 96'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 1'b0; pt_i = '0; key_i = '0;
    void'($urandom(32'h5EED_0101));
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R9 flags in reset", {94'd0, busy_o, done_o}, 96'd0);
    check(ct_o == 64'd0, "R9 output in reset", 96'(ct_o), 96'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R9 flags after reset", {94'd0, busy_o, done_o}, 96'd0);

    // all-zero control: SP network on data, Feistel on key
    run_block(64'h0, 96'h0, "R4 R5 R7 R8 ciphertext, ctrl all zero, zero inputs", 1'b0);
    run_block(64'h0123_4567_89AB_CDEF, {32'h0, 64'hFEDC_BA98_7654_3210},
              "R4 R5 R7 R8 ciphertext, ctrl all zero", 1'b0);
    // all-one control: Feistel network on data, SP on key
    run_block(64'h0123_4567_89AB_CDEF, {32'hFFFF_FFFF, 64'hFEDC_BA98_7654_3210},
              "R4 R6 R7 R8 ciphertext, ctrl all one", 1'b0);
    run_block(64'hFFFF_FFFF_FFFF_FFFF, {32'hFFFF_FFFF, 64'h0},
              "R4 R6 R7 ciphertext, ctrl all one, ones data", 1'b0);
    // alternating and single-bit control words
    run_block(64'hDEAD_BEEF_0BAD_F00D, {32'hAAAA_AAAA, 64'h1357_9BDF_2468_ACE0},
              "R4 ciphertext, ctrl alternating", 1'b0);
    run_block(64'hDEAD_BEEF_0BAD_F00D, {32'h8000_0001, 64'h1357_9BDF_2468_ACE0},
              "R4 ciphertext, ctrl ends set", 1'b0);
    // start pulse in the middle of a run
    run_block(64'h5555_AAAA_3333_CCCC, {32'h0F0F_0F0F, 64'h0011_2233_4455_6677},
              "R3 ciphertext unaffected by start while busy", 1'b1);
    // random blocks
    for (int t = 0; t < 16; t++) begin
      logic [63:0] p;
      logic [95:0] k;
      p = {$urandom(), $urandom()};
      k = {$urandom(), $urandom(), $urandom()};
      run_block(p, k, "R4 ciphertext, random block", (t % 4) == 3);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule